// File: doc/BRIEF.md
# Debounced Enter-Key Input Handshake

This block sits between a mechanical enter key and the control unit of a small processor. The key line is asynchronous and bounces. The block first brings it into the clock domain through a flip-flop chain. A counter then filters the bounce and holds a single accepted key level. A small handshake machine turns each accepted press into exactly one completion of an input instruction.

The control unit raises `in_req` while it sits in its input state. On the first clean press seen while the request is high, the block latches the data switches into `data_q` and pulses `done` for one clock, and the control unit then goes back to fetch. After any press, the key must be seen released before another press can count. Holding the key down, or bouncing it, therefore finishes only one input instruction, even when two input instructions run back to back. Right after reset the machine checks for release in the same way, so the first real press already counts and no dummy press is needed.

Top module: `enter_entry_unit`

## Requirements
- R1: The raw key line reaches the debounce logic only through a chain of at least two flip-flops clocked by `clk`. The key line is never used as a clock.
- R2: The debounce counter restarts whenever the synchronized sample differs from the sample of the cycle before. The accepted level (`stable_level`) takes the new sample value only after the sample has stayed constant, and different from the accepted level, for `DEBOUNCE_CYCLES` consecutive counts. A pulse shorter than that leaves `stable_level` unchanged.
- R3: `stable_level` is 1 while the key is held down after debouncing, and 0 after it has been released and debounced.
- R4: `done` is a single-cycle pulse (1 = input complete). It is raised only when `in_req` was 1 and the accepted level had just risen from 0 to 1 while the handshake was armed.
- R5: `data_q` loads `sw_data` on the same clock edge that raises `done`, and holds its value at all other times, even when `sw_data` changes.
- R6: After a press has been accepted, no further `done` occurs until the accepted level has gone back to 0. A key held down while `in_req` stays 1 completes exactly one input.
- R7: A press whose rising edge arrives while `in_req` is 0 is discarded. Raising `in_req` while the key is still held gives no `done`. A release followed by a new press is needed.
- R8: After reset, the first clean press made with `in_req` at 1 completes an input, with no extra press beforehand.
- R9: Synchronous active-low reset clears the synchronizer, the counter and the accepted level (to 0), and returns the handshake to waiting-for-release. After reset, `data_q` is 0, `done` is 0 and `stable_level` is 0.
- R10: A press or release that bounces, with level changes shorter than the debounce window, yields exactly one `done` per press, carrying the switch value present at acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Design clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enter_raw | input | 1 | Asynchronous, bouncy enter-key line (1 = pressed) |
| sw_data | input | DATA_W | Data switch bus to be captured |
| in_req | input | 1 | Control unit is waiting in its input state |
| data_q | output | DATA_W | Captured data word |
| done | output | 1 | One-cycle pulse: input accepted, `data_q` updated |
| stable_level | output | 1 | Debounced key level, for debug |

## Verification
The bench builds the unit with `DEBOUNCE_CYCLES` set to 8 instead of the million-count default. With that value, a full press, a hold and a release each fit in a few dozen cycles, and bursts of one- and two-cycle bounces fall well inside the filter window. This makes it possible to run held keys with a continuous request, presses made before the request, short glitches and data changes after capture within one short run. The default 8-bit data width is kept, so distinct switch patterns are tied to individual presses.

// File: rtl/enter_pkg.sv
// Package: shared types of the enter-key entry unit.
// Assumes: single clock domain; the handshake has only the two states below.
package enter_pkg;

    typedef enum logic [0:0] {
        HS_WAIT_RELEASE = 1'b0,
        HS_ARMED        = 1'b1
    } hs_state_t;

endpackage

// File: rtl/enter_sync.sv
// Module: enter_sync
// Brings an asynchronous single-bit line into the clk domain through a chain
// of STAGES flip-flops. Assumes STAGES >= 2; only the last stage is used.
module enter_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    // First stage: capture the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= async_in;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Later stages: pass the previous stage on by one clock.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[g] <= 1'b0;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

    initial begin
        if (STAGES < 2) $error("enter_sync: STAGES must be at least 2");
    end

    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sync_out) |-> $past(chain_q[STAGES-2]) == sync_out) else $error("sync"); // R1

endmodule

// File: rtl/enter_debounce.sv
// Module: enter_debounce
// Counter filter: the accepted level follows the synchronized sample only
// after the sample has stayed constant, and different from the accepted
// level, for DEBOUNCE_CYCLES counts. Any sample change restarts the count.
// Assumes: DEBOUNCE_CYCLES >= 1; sample already synchronous to clk.
module enter_debounce #(
    parameter int DEBOUNCE_CYCLES = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sample,
    output logic level
);

    localparam int CNT_W = $clog2(DEBOUNCE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEBOUNCE_CYCLES - 1);

    logic             last_q;
    logic [CNT_W-1:0] cnt_q;

    // Track the sample history, count quiet cycles and update the level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
            cnt_q  <= '0;
            level  <= 1'b0;
        end else begin
            last_q <= sample;
            if (sample != last_q) begin
                cnt_q <= '0;
            end else if (sample == level) begin
                cnt_q <= '0;
            end else if (cnt_q == LIMIT) begin
                level <= sample;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_LEVEL_FULL_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level) |-> $past(cnt_q) == LIMIT) else $error("window"); // R2
    AST_LEVEL_TAKES_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level) |-> level == $past(sample)) else $error("sample"); // R2
    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT) else $error("count"); // R2

endmodule

// File: rtl/enter_handshake.sv
// Module: enter_handshake
// Turns rising edges of the debounced key level into input completions.
// Armed only after the level has been seen low; one accepted press per
// release. Assumes level is debounced and synchronous to clk.
module enter_handshake
    import enter_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              level,
    input  logic              req,
    input  logic [DATA_W-1:0] sw_data,
    output logic [DATA_W-1:0] data_q,
    output logic              done
);

    hs_state_t state_q;
    logic      level_prev_q;
    logic      rise;

    // Rising edge of the accepted level: high now, low one cycle ago.
    assign rise = level & ~level_prev_q;

    // Release/arm sequencing, data capture and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= HS_WAIT_RELEASE;
            level_prev_q <= 1'b0;
            done         <= 1'b0;
            data_q       <= '0;
        end else begin
            level_prev_q <= level;
            done         <= 1'b0;
            case (state_q)
                HS_WAIT_RELEASE: begin
                    if (!level) state_q <= HS_ARMED;
                end
                HS_ARMED: begin
                    if (rise) begin
                        if (req) begin
                            done   <= 1'b1;
                            data_q <= sw_data;
                        end
                        state_q <= HS_WAIT_RELEASE;
                    end
                end
                default: state_q <= HS_WAIT_RELEASE;
            endcase
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("single"); // R4
    AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(req)) else $error("req"); // R4
    AST_DONE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(level)) else $error("level"); // R4
    AST_DONE_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state_q) == HS_ARMED) else $error("armed"); // R6
    AST_DONE_THEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> state_q == HS_WAIT_RELEASE) else $error("wait"); // R6
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(data_q)) else $error("hold"); // R5

endmodule

// File: rtl/enter_entry_unit.sv
// Module: enter_entry_unit (top)
// Enter-key conditioning for an input instruction: synchronizer, counter
// debouncer and request/release handshake. Assumes one clock domain;
// enter_raw may change at any time; in_req is synchronous to clk.
module enter_entry_unit #(
    parameter int DATA_W          = 8,
    parameter int DEBOUNCE_CYCLES = 1_000_000,
    parameter int SYNC_STAGES     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enter_raw,
    input  logic [DATA_W-1:0] sw_data,
    input  logic              in_req,
    output logic [DATA_W-1:0] data_q,
    output logic              done,
    output logic              stable_level
);

    logic key_sync;

    enter_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (enter_raw),
        .sync_out (key_sync)
    );

    enter_debounce #(
        .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES)
    ) u_debounce (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (key_sync),
        .level  (stable_level)
    );

    enter_handshake #(
        .DATA_W (DATA_W)
    ) u_handshake (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (stable_level),
        .req     (in_req),
        .sw_data (sw_data),
        .data_q  (data_q),
        .done    (done)
    );

endmodule

// File: tb/tb_enter_entry_unit.sv
// Scoreboard bench: drive tasks queue the expected captured words, and a
// monitor pops one per done pulse and compares it with data_q.
module tb_enter_entry_unit;

    localparam int CLK_PERIOD = 20;
    localparam int DATA_W     = 8;
    localparam int DEB        = 8;
    localparam int HOLD       = 40;
    localparam int WATCHDOG   = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              enter_raw = 1'b0;
    logic [DATA_W-1:0] sw_data = '0;
    logic              in_req = 1'b0;
    logic [DATA_W-1:0] data_q;
    logic              done;
    logic              stable_level;

    int checks = 0;
    int fails  = 0;
    int done_count = 0;
    int cycles = 0;
    logic [DATA_W-1:0] exp_q[$];
    string cur_req = "R4";

    always #(CLK_PERIOD/2) clk = ~clk;

    enter_entry_unit #(
        .DATA_W          (DATA_W),
        .DEBOUNCE_CYCLES (DEB),
        .SYNC_STAGES     (2)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enter_raw    (enter_raw),
        .sw_data      (sw_data),
        .in_req       (in_req),
        .data_q       (data_q),
        .done         (done),
        .stable_level (stable_level)
    );

    task automatic check_eq(input string req, input string what,
                            input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    // Monitor: pop and compare one expected word per done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            done_count++;
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL %s unexpected done: actual data %0h expected none",
                         cur_req, data_q);
            end else begin
                logic [DATA_W-1:0] e;
                e = exp_q.pop_front();
                if (data_q !== e) begin
                    fails++;
                    $display("FAIL R5 captured data: actual %0h expected %0h", data_q, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Move the key to lvl with a burst of short bounces, then hold it.
    task automatic key_to(input logic lvl);
        for (int i = 0; i < 4; i++) begin
            enter_raw = lvl;  wait_cyc(2);
            enter_raw = ~lvl; wait_cyc(1);
        end
        enter_raw = lvl;
        wait_cyc(HOLD);
    endtask

    initial begin
        int base;
        wait_cyc(5);
        // R9: reset state
        check_eq("R9", "data_q after reset", data_q, 0);
        check_eq("R9", "done after reset", done, 0);
        check_eq("R9", "stable_level after reset", stable_level, 0);
        rst_n = 1'b1;
        wait_cyc(3);

        // R2: a pulse shorter than the window is filtered out
        cur_req = "R2";
        in_req = 1'b1;
        base = done_count;
        enter_raw = 1'b1; wait_cyc(DEB - 3);
        enter_raw = 1'b0; wait_cyc(30);
        check_eq("R2", "stable_level after glitch", stable_level, 0);
        check_eq("R2", "done count after glitch", done_count - base, 0);

        // R8 / R10: first bouncy press after reset completes one input
        cur_req = "R10";
        sw_data = 8'hA5;
        exp_q.push_back(8'hA5);
        base = done_count;
        key_to(1'b1);
        check_eq("R3", "stable_level while held", stable_level, 1);
        check_eq("R8", "first press completes", done_count - base, 1);
        check_eq("R1", "key passed to debounce", stable_level, 1);
        key_to(1'b0);
        check_eq("R3", "stable_level after release", stable_level, 0);
        check_eq("R10", "release adds no done", done_count - base, 1);

        // R6: held key with continuous request gives one input only
        cur_req = "R6";
        sw_data = 8'h3C;
        exp_q.push_back(8'h3C);
        base = done_count;
        key_to(1'b1);
        wait_cyc(60);
        check_eq("R6", "done count with key held", done_count - base, 1);
        // R5: switch changes after capture do not reach data_q
        sw_data = 8'hFF;
        wait_cyc(5);
        check_eq("R5", "data_q held after capture", data_q, 8'h3C);
        key_to(1'b0);

        // R7: press made before the request is discarded
        cur_req = "R7";
        in_req = 1'b0;
        sw_data = 8'h11;
        base = done_count;
        key_to(1'b1);
        check_eq("R7", "press without request", done_count - base, 0);
        in_req = 1'b1;
        wait_cyc(HOLD);
        check_eq("R7", "request raised while held", done_count - base, 0);
        check_eq("R7", "data_q unchanged", data_q, 8'h3C);
        key_to(1'b0);
        sw_data = 8'h22;
        exp_q.push_back(8'h22);
        key_to(1'b1);
        check_eq("R7", "new press after release", done_count - base, 1);
        key_to(1'b0);
        in_req = 1'b0;

        wait_cyc(5);
        check_eq("R10", "scoreboard drained", exp_q.size(), 0);
        check_eq("R4", "done low at end", done, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule